// File: doc/BRIEF.md
# Parallel Port Byte Sender

This block streams a fixed-size buffer of samples to a host over a byte-wide parallel link. It reads the sample store one word at a time through a synchronous read port. It presents each word on a data bus and paces every transfer with a two-wire, fully interlocked four-phase handshake. The block drives the wait line. The host answers on the strobe line. The link has no fixed timing: each byte moves only as fast as the host acknowledges it.

A one-cycle start request in idle begins a pass at address zero. The block then walks the addresses upward. For each address it places the word on the bus, pulls wait low, and holds there until the synchronised strobe reads high. It then releases wait and holds until the strobe reads low again. After the last address has completed its handshake, the block raises a single-cycle done pulse and returns to idle. At that point the producer can refill the store.

Top module: `pport_sender`

## Requirements
- R1: While reset is asserted, wait_o is 1, done_o is 0 and data_o is 0, with the reset acting without a clock edge.
- R2: A start_i pulse in idle begins a pass whose bytes are the store words at addresses 0, 1, 2, … in increasing order.
- R3: Each time wait_o falls to 0, data_o already equals the store word at the address being sent, where the store returns the word one clock after rd_addr_o presents it.
- R4: wait_o stays 0 until the strobe is seen high. It returns to 1 on the third rising clock edge after strobe_i rises, because the strobe passes through two synchroniser flops before the controller uses it.
- R5: After wait_o returns to 1, the next byte is not offered (wait_o stays 1) for as long as strobe_i stays high.
- R6: data_o keeps its value from the fall of wait_o until the next byte is loaded, covering both handshake phases.
- R7: A pass sends exactly DEPTH (128) bytes. Afterwards wait_o stays 1 and the host strobe has no effect until the next start.
- R8: done_o is a one-cycle pulse. It goes high on the third rising edge after strobe_i falls at the end of the last byte's handshake, and at no other time.
- R9: A start_i pulse while a pass is in progress is ignored and does not disturb the address order.
- R10: In idle after a pass, data_o holds the last byte sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a pass when idle |
| strobe_i | input | 1 | Host strobe, asynchronous to clk |
| rd_addr_o | output | ADDR_W (7) | Sample store read address |
| rd_data_i | input | DATA_W (8) | Store word, valid one cycle after address |
| data_o | output | DATA_W (8) | Byte presented to the host |
| wait_o | output | 1 | Low while a byte is offered |
| done_o | output | 1 | One-cycle pulse at end of pass |

## Verification
Two events can land on the same clock: the last handshake's release and the done pulse, and a fresh start request and an ongoing release phase. The bench drives start_i while the host holds the strobe high in mid-pass. It then checks that the byte order continues unbroken from the next address. On the final byte it counts edges from the strobe fall. It expects done_o high on exactly the third edge and low on the fourth. Across both, wait_o must stay high and no extra byte may be offered.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FETCH   = 3'd1,
    ST_LATCH   = 3'd2,
    ST_OFFER   = 3'd3,
    ST_RELEASE = 3'd4
  } xfer_state_t;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pport_addr_ctr.sv
module pport_addr_ctr #(
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = clr_i | inc_i;
    addr_d  = clr_i ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == LAST_ADDR);
endmodule

// File: rtl/pport_fsm.sv
module pport_fsm
  import pport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic strb_s_i,
  input  logic last_i,
  output logic clr_o,
  output logic inc_o,
  output logic latch_o,
  output logic wait_o,
  output logic done_o
);
  xfer_state_t state_q, state_d;
  logic        done_d, done_q, wait_q;

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    latch_o = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          clr_o   = 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH:  state_d = ST_LATCH;
      ST_LATCH: begin
        latch_o = 1'b1;
        state_d = ST_OFFER;
      end
      ST_OFFER: begin
        if (strb_s_i) state_d = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (!strb_s_i) begin
          if (last_i) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            inc_o   = 1'b1;
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= (state_d != ST_OFFER);
      done_q  <= done_d;
    end
  end

  assign wait_o = wait_q;
  assign done_o = done_q;
endmodule

// File: rtl/pport_sender.sv
module pport_sender #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 128,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              strobe_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              wait_o,
  output logic              done_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              strb_s, clr, inc, latch, last;
  logic [DATA_W-1:0] data_q;

  // assertion asynchronous, release aligned to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pport_sync #(.STAGES(SYNC_STAGES)) i_strb_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(strobe_i), .q_o(strb_s)
  );

  pport_addr_ctr #(.DEPTH(DEPTH)) i_addr (
    .clk(clk), .rst_n(rst_int_n), .clr_i(clr), .inc_i(inc),
    .addr_o(rd_addr_o), .last_o(last)
  );

  pport_fsm i_fsm (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .strb_s_i(strb_s),
    .last_i(last), .clr_o(clr), .inc_o(inc), .latch_o(latch),
    .wait_o(wait_o), .done_o(done_o)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  data_q <= '0;
    else if (latch)  data_q <= rd_data_i;
  end
  assign data_o = data_q;
endmodule

// File: rtl/pport_sender_chk.sv
module pport_sender_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_i,
  input logic              strb_s,
  input logic              wait_o,
  input logic              done_o,
  input logic [DATA_W-1:0] data_o,
  input logic [ADDR_W-1:0] rd_addr_o
);
  a_r4_release_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_o) |-> $past(strobe_i, 3));

  a_r5_offer_needs_low_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_o) |-> !$past(strb_s));

  a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_o && $past(!wait_o)) |-> $stable(data_o));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_with_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> wait_o);

  a_r2_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_o != $past(rd_addr_o)) |->
      (rd_addr_o == $past(rd_addr_o) + ADDR_W'(1)) || (rd_addr_o == '0));
endmodule

bind pport_sender pport_sender_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_int_n), .strobe_i(strobe_i), .strb_s(strb_s),
  .wait_o(wait_o), .done_o(done_o), .data_o(data_o), .rd_addr_o(rd_addr_o)
);

// File: tb/test_pport_sender.sv
module test_pport_sender;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       strobe_i = 1'b0;
  logic [6:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic [7:0] data_o;
  logic       wait_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] pat_mul = 8'd1;
  logic [7:0] pat_add = 8'd0;

  always #2 clk = ~clk;

  // synchronous-read sample store model
  always_ff @(posedge clk) rd_data_i <= 8'(rd_addr_o * pat_mul + pat_add);

  pport_sender i_pport_sender (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .strobe_i(strobe_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .data_o(data_o),
    .wait_o(wait_o), .done_o(done_o)
  );

  // {mul, add, hold cycles, poke start mid-pass}
  localparam logic [23:0] VEC [0:3] = '{
    {8'd1,  8'd0,   4'd0, 4'd0},
    {8'd3,  8'd17,  4'd2, 4'd1},
    {8'd29, 8'd200, 4'd5, 4'd0},
    {8'd7,  8'd85,  4'd1, 4'd1}
  };

  function automatic logic [7:0] expw(input int a);
    return 8'(a * pat_mul + pat_add);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_pass(input int hold, input bit poke);
    logic [7:0] held;
    pulse_start();
    for (int i = 0; i < DEPTH; i++) begin
      int k = 0;
      while (wait_o && k < 30) begin @(negedge clk); k++; end
      check(!wait_o, "R2 byte offered", wait_o, 0);
      check(data_o == expw(i), "R3 data at offer", data_o, expw(i));
      held = data_o;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        check(!wait_o && data_o == held, "R4 wait held low", wait_o, 0);
      end
      strobe_i = 1'b1;
      @(negedge clk); @(negedge clk);
      check(!wait_o, "R4 synchroniser latency", wait_o, 0);
      @(negedge clk);
      check(wait_o, "R4 wait released", wait_o, 1);
      if (poke && i == 5) begin
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;   // R9
      end
      for (int h = 0; h < hold + 1; h++) begin
        @(negedge clk);
        check(wait_o && !done_o, "R5 no next offer while strobe high", wait_o, 1);
        check(data_o == held, "R6 data stable in release", data_o, held);
      end
      strobe_i = 1'b0;
      @(negedge clk); @(negedge clk);
      check(!done_o, "R8 done not early", done_o, 0);
      @(negedge clk);
      if (i == DEPTH - 1) begin
        check(done_o, "R8 done pulse", done_o, 1);
        @(negedge clk);
        check(!done_o, "R8 done one cycle", done_o, 0);
      end else begin
        check(!done_o, "R8 no done mid pass", done_o, 0);
      end
    end
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      check(wait_o && !done_o, "R7 idle after pass", wait_o, 1);
    end
    check(data_o == expw(DEPTH - 1), "R10 last byte held", data_o, expw(DEPTH - 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wait_o && !done_o && data_o == 8'd0, "R1 reset state", data_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      pat_mul = VEC[v][23:16];
      pat_add = VEC[v][15:8];
      run_pass(int'(VEC[v][7:4]), VEC[v][0]);
    end
    // R7: strobe activity at idle is ignored
    for (int c = 0; c < 6; c++) begin
      strobe_i = ~strobe_i;
      repeat (4) @(negedge clk);
      check(wait_o && !done_o, "R7 strobe ignored in idle", wait_o, 1);
    end
    strobe_i = 1'b0;
    repeat (4) @(negedge clk);
    // R1: asynchronous reset in the middle of a pass
    pulse_start();
    repeat (4) @(negedge clk);
    check(!wait_o, "R2 offer before reset", wait_o, 0);
    #1 rst_n = 1'b0;
    #0.5;
    check(wait_o && !done_o && data_o == 8'd0, "R1 async reset", wait_o, 1);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pat_mul = 8'd5; pat_add = 8'd3;
    run_pass(0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule